// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block takes a set of clock synthesizers from power-on to normal running, one at a time. A request names one synthesizer and carries a divider set: a reference predivider, a feedback multiplier, a fractional word and a post multiplier. The sequencer first checks the set against two frequency windows. If the set passes, it programs the four divider fields into the synthesizer's control registers and waits out a settling time chosen for that synthesizer. It then polls the synthesizer's lock indicator. Only after lock has been seen does it take the synthesizer out of bypass.

All synthesizers start in bypass after reset, except the one that drives the memory interface. A configuration that fails a frequency check is refused before any register is written. A synthesizer that does not lock within a bounded polling window is left in bypass, and an error flag is raised. The outcome flags stay set until the next request is accepted. Requests that arrive while a sequence is running are dropped.

The input reference frequency and the system clock frequency are elaboration parameters. The settling times are converted to system clock cycles by rounding up. With the defaults (27 MHz reference, 200 MHz system clock) the audio synthesizer (index 3) waits 1600 cycles, and every other synthesizer waits 1000 cycles.

Top module: `pll_bringup_ctrl`

## Requirements
- R1: After reset, `bypass_o` is 1 for every synthesizer except index `MEM_IDX` (default 1), which is 0. `busy_o`, `wr_en_o`, `done_o`, `err_range_o` and `err_lock_o` are all 0.
- R2: A request is refused, with `err_range_o` set, no write issued and `bypass_o` left unchanged, unless 800·P ≤ CLKIN·N ≤ 1600·P and 10·P ≤ CLKIN ≤ 60·P (frequencies in MHz).
- R3: An accepted configuration produces exactly four writes on consecutive cycles to the requested index (`wr_pll_o`). `wr_sel_o` takes the values 0 = P, 1 = N, 2 = FREQ, 3 = M, in that order. The P, N and FREQ values are zero-extended in `wr_data_o`.
- R4: On the M write, `wr_data_o[7:0]` holds M and `wr_data_o[11:8]` holds H. H is 10 when M·FREQ is a multiple of 8, and 0 otherwise.
- R5: The target synthesizer's bypass bit is 1 from the first divider write until it is released. A synthesizer that was already running is put back into bypass when it is reprogrammed.
- R6: Lock is not sampled until the settling time has elapsed. A bypass bit falls more than 1600 cycles after the M write for the audio index (3), and more than 1000 cycles after it for any other index.
- R7: A bypass bit falls only after lock was seen for that synthesizer. `done_o` is then set and `busy_o` returns to 0.
- R8: If lock is not seen within `POLL_CYC` (default 256) cycles after the settling wait, `err_lock_o` is set and the synthesizer stays in bypass.
- R9: A request presented while `busy_o` is 1 is ignored. It produces no writes and changes no bypass bit.
- R10: `done_o`, `err_range_o` and `err_lock_o` hold their values until the next request is accepted, which clears all three. Only one of them is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_pll_i | input | IDX_W | Index of the synthesizer to bring up |
| req_p_i | input | P_W | Reference predivider P |
| req_n_i | input | N_W | Feedback multiplier N |
| req_freq_i | input | F_W | Fractional word FREQ |
| req_m_i | input | M_W | Post multiplier M |
| busy_o | output | 1 | Sequence in progress |
| wr_en_o | output | 1 | Register write strobe |
| wr_pll_o | output | IDX_W | Synthesizer addressed by the write |
| wr_sel_o | output | 2 | Field select: 0 P, 1 N, 2 FREQ, 3 M with H |
| wr_data_o | output | DATA_W | Write data |
| lock_i | input | NUM_PLL | Lock indicator per synthesizer, 1 = locked |
| bypass_o | output | NUM_PLL | Bypass control per synthesizer, 1 = bypassed |
| done_o | output | 1 | Last sequence ended with a release |
| err_range_o | output | 1 | Last request failed a frequency window |
| err_lock_o | output | 1 | Last sequence timed out waiting for lock |

## Verification
The assertions rely on two things about `lock_i`. First, it is driven by a lock model that only sees the register writes. Second, a bypass release is always preceded by lock being high two cycles earlier on some synthesizer. The bench's lock model clears a synthesizer's lock when any write reaches it, and raises lock again after a chosen delay. That delay is either short, longer than the settling wait but inside the poll window, or never. This keeps every lock edge tied to a write. Requests are pulsed for one cycle from the falling edge. The random divider values cover both sides of each frequency window, and P = 0 is included.

// File: rtl/pll_bringup_pkg.sv
package pll_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WRITE,
    ST_SETTLE,
    ST_POLL,
    ST_RELEASE,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_P    = 2'd0,
    SEL_N    = 2'd1,
    SEL_FREQ = 2'd2,
    SEL_M    = 2'd3
  } field_sel_t;

  localparam logic [3:0] H_ALIGNED = 4'd10;

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int P_W       = 8,
  parameter int N_W       = 12,
  parameter int F_W       = 8,
  parameter int M_W       = 8,
  parameter int CLKIN_MHZ = 27,
  parameter int VCO_LO    = 800,
  parameter int VCO_HI    = 1600,
  parameter int REF_LO    = 10,
  parameter int REF_HI    = 60
) (
  input  logic [P_W-1:0] p_i,
  input  logic [N_W-1:0] n_i,
  input  logic [F_W-1:0] freq_i,
  input  logic [M_W-1:0] m_i,
  output logic           cfg_ok_o,
  output logic [3:0]     h_o
);
  import pll_bringup_pkg::*;

  localparam int PW = M_W + F_W;
  localparam logic [31:0] CLK = 32'(CLKIN_MHZ);

  logic [31:0] vco_val, vco_lo, vco_hi, ref_lo, ref_hi;
  logic [PW-1:0] prod;

  // Window checks use multiply-and-compare instead of division.
  always_comb begin
    vco_val = CLK * 32'(n_i);
    vco_lo  = 32'(VCO_LO) * 32'(p_i);
    vco_hi  = 32'(VCO_HI) * 32'(p_i);
    ref_lo  = 32'(REF_LO) * 32'(p_i);
    ref_hi  = 32'(REF_HI) * 32'(p_i);
    cfg_ok_o = (vco_val >= vco_lo) && (vco_val <= vco_hi) &&
               (CLK >= ref_lo) && (CLK <= ref_hi);
  end

  always_comb begin
    prod = PW'(m_i) * PW'(freq_i);
    h_o  = (prod[2:0] == 3'd0) ? H_ALIGNED : 4'd0;
  end

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pll_bypass_bank.sv
module pll_bypass_bank #(
  parameter int NUM_PLL = 4,
  parameter int IDX_W   = 2,
  parameter int MEM_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic             clr_i,
  output logic [NUM_PLL-1:0] bypass_o
);
  for (genvar g = 0; g < NUM_PLL; g++) begin : g_byp
    localparam logic RST_VAL = (g != MEM_IDX);
    logic hit, en, d, q;
    always_comb begin
      hit = (idx_i == IDX_W'(g));
      en  = hit && (set_i || clr_i);
      d   = set_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (en) q <= d;
    end
    assign bypass_o[g] = q;
  end

endmodule

// File: rtl/pll_bringup_ctrl.sv
module pll_bringup_ctrl
  import pll_bringup_pkg::*;
#(
  parameter int NUM_PLL         = 4,
  parameter int IDX_W           = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1,
  parameter int MEM_IDX         = 1,
  parameter int AUDIO_IDX       = 3,
  parameter int P_W             = 8,
  parameter int N_W             = 12,
  parameter int F_W             = 8,
  parameter int M_W             = 8,
  parameter int DATA_W          = 16,
  parameter int CLKIN_MHZ       = 27,
  parameter int SYSCLK_MHZ      = 200,
  parameter int SETTLE_NS_AUDIO = 8000,
  parameter int SETTLE_NS_OTHER = 5000,
  parameter int POLL_CYC        = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [IDX_W-1:0]   req_pll_i,
  input  logic [P_W-1:0]     req_p_i,
  input  logic [N_W-1:0]     req_n_i,
  input  logic [F_W-1:0]     req_freq_i,
  input  logic [M_W-1:0]     req_m_i,
  output logic               busy_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_pll_o,
  output logic [1:0]         wr_sel_o,
  output logic [DATA_W-1:0]  wr_data_o,
  input  logic [NUM_PLL-1:0] lock_i,
  output logic [NUM_PLL-1:0] bypass_o,
  output logic               done_o,
  output logic               err_range_o,
  output logic               err_lock_o
);
  localparam int SET_AUD = (SETTLE_NS_AUDIO * SYSCLK_MHZ + 999) / 1000;
  localparam int SET_OTH = (SETTLE_NS_OTHER * SYSCLK_MHZ + 999) / 1000;
  localparam int MAX_A   = (SET_AUD > SET_OTH) ? SET_AUD : SET_OTH;
  localparam int MAX_W   = (MAX_A > POLL_CYC) ? MAX_A : POLL_CYC;
  localparam int CNT_W   = $clog2(MAX_W + 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [P_W-1:0]   p_q;
  logic [N_W-1:0]   n_q;
  logic [F_W-1:0]   f_q;
  logic [M_W-1:0]   m_q;
  logic [1:0]       wcnt_q;
  logic             done_q, erng_q, elock_q;

  logic             accept, cfg_ok, lock_sel, tmr_zero, tmr_load, tmr_run;
  logic             last_wr, settle_end, lock_fail;
  logic [3:0]       h_val;
  logic [CNT_W-1:0] tmr_val;

  pll_cfg_check #(
    .P_W(P_W), .N_W(N_W), .F_W(F_W), .M_W(M_W), .CLKIN_MHZ(CLKIN_MHZ),
    .VCO_LO(800), .VCO_HI(1600), .REF_LO(10), .REF_HI(60)
  ) u_check (
    .p_i(p_q), .n_i(n_q), .freq_i(f_q), .m_i(m_q),
    .cfg_ok_o(cfg_ok), .h_o(h_val)
  );

  pll_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .run_i(tmr_run), .zero_o(tmr_zero)
  );

  pll_bypass_bank #(.NUM_PLL(NUM_PLL), .IDX_W(IDX_W), .MEM_IDX(MEM_IDX)) u_byp (
    .clk(clk), .rst_n(rst_n), .idx_i(idx_q),
    .set_i((state_q == ST_WRITE) && (wcnt_q == 2'd0)),
    .clr_i(state_q == ST_RELEASE),
    .bypass_o(bypass_o)
  );

  always_comb begin
    lock_sel   = lock_i[idx_q];
    accept     = (state_q == ST_IDLE) && req_valid_i;
    last_wr    = (state_q == ST_WRITE) && (wcnt_q == 2'd3);
    settle_end = (state_q == ST_SETTLE) && tmr_zero;
    lock_fail  = (state_q == ST_POLL) && !lock_sel && tmr_zero;
    tmr_load   = last_wr || settle_end;
    tmr_run    = (state_q == ST_SETTLE) || (state_q == ST_POLL);
    if (settle_end)                       tmr_val = CNT_W'(POLL_CYC - 1);
    else if (idx_q == IDX_W'(AUDIO_IDX))  tmr_val = CNT_W'(SET_AUD - 1);
    else                                  tmr_val = CNT_W'(SET_OTH - 1);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_CHECK;
      ST_CHECK:   state_d = cfg_ok ? ST_WRITE : ST_IDLE;
      ST_WRITE:   if (wcnt_q == 2'd3) state_d = ST_SETTLE;
      ST_SETTLE:  if (tmr_zero) state_d = ST_POLL;
      ST_POLL:    if (lock_sel) state_d = ST_RELEASE;
                  else if (tmr_zero) state_d = ST_IDLE;
      ST_RELEASE: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; p_q <= '0; n_q <= '0; f_q <= '0; m_q <= '0;
    end else if (accept) begin
      idx_q <= req_pll_i; p_q <= req_p_i; n_q <= req_n_i;
      f_q   <= req_freq_i; m_q <= req_m_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wcnt_q <= 2'd0;
    else if (state_q == ST_WRITE) wcnt_q <= wcnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; erng_q <= 1'b0; elock_q <= 1'b0;
    end else begin
      if (accept || state_q == ST_DONE)                done_q  <= (state_q == ST_DONE);
      if (accept || (state_q == ST_CHECK && !cfg_ok))  erng_q  <= !accept;
      if (accept || lock_fail)                         elock_q <= !accept;
    end
  end

  always_comb begin
    unique case (wcnt_q)
      SEL_P:    wr_data_o = DATA_W'(p_q);
      SEL_N:    wr_data_o = DATA_W'(n_q);
      SEL_FREQ: wr_data_o = DATA_W'(f_q);
      default:  wr_data_o = DATA_W'({h_val, m_q});
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign wr_en_o     = (state_q == ST_WRITE);
  assign wr_pll_o    = idx_q;
  assign wr_sel_o    = wcnt_q;
  assign done_o      = done_q;
  assign err_range_o = erng_q;
  assign err_lock_o  = elock_q;

endmodule

// File: rtl/pll_bringup_sva.sv
module pll_bringup_sva #(
  parameter int NUM_PLL = 4,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               wr_en_o,
  input logic [IDX_W-1:0]   wr_pll_o,
  input logic [1:0]         wr_sel_o,
  input logic [DATA_W-1:0]  wr_data_o,
  input logic [NUM_PLL-1:0] lock_i,
  input logic [NUM_PLL-1:0] bypass_o,
  input logic               done_o,
  input logic               err_range_o,
  input logic               err_lock_o
);
  p_wr_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);

  p_wr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_sel_o != 2'd0) |->
      ($past(wr_en_o) && ($past(wr_sel_o) == wr_sel_o - 2'd1) && $stable(wr_pll_o)));

  p_no_write_on_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_range_o) |-> !$past(wr_en_o));

  p_release_after_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(bypass_o) & ~bypass_o)) |-> $past(|lock_i, 2));

  p_single_bypass_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bypass_o ^ $past(bypass_o)) <= 1);

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && (err_range_o || err_lock_o)) && !(err_range_o && err_lock_o));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);

  p_lock_err_keeps_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_lock_o) |-> (bypass_o[wr_pll_o] && !busy_o));

  logic unused_data;
  assign unused_data = ^wr_data_o;

endmodule

bind pll_bringup_ctrl pll_bringup_sva #(
  .NUM_PLL(NUM_PLL), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .wr_en_o(wr_en_o),
  .wr_pll_o(wr_pll_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
  .lock_i(lock_i), .bypass_o(bypass_o), .done_o(done_o),
  .err_range_o(err_range_o), .err_lock_o(err_lock_o)
);

// File: tb/tb_pll_bringup_ctrl.sv
module tb_pll_bringup_ctrl;
  localparam int NP = 4;
  localparam int CLKIN = 27;
  localparam int S_AUD = 1600;
  localparam int S_OTH = 1000;
  localparam int POLL  = 256;
  localparam int NEVER = 32'h7fffffff;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_pll;
  logic [7:0] req_p, req_f, req_m;
  logic [11:0] req_n;
  logic busy, wr_en, done, erng, elock;
  logic [1:0] wr_pll, wr_sel;
  logic [15:0] wr_data;
  logic [NP-1:0] lock, bypass;

  int checks = 0, fails = 0;
  int cyc = 0;
  int wr_total = 0, seq_err = 0;
  logic [15:0] wdata [4];
  logic [1:0]  wpll  [4];
  int m_wr_cyc = 0, fall_cyc = -1;
  int lock_cnt [NP];
  int lock_dly [NP];
  logic [NP-1:0] exp_byp;

  always #2.5 clk = ~clk;

  pll_bringup_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_pll_i(req_pll),
    .req_p_i(req_p), .req_n_i(req_n), .req_freq_i(req_f), .req_m_i(req_m),
    .busy_o(busy), .wr_en_o(wr_en), .wr_pll_o(wr_pll), .wr_sel_o(wr_sel),
    .wr_data_o(wr_data), .lock_i(lock), .bypass_o(bypass), .done_o(done),
    .err_range_o(erng), .err_lock_o(elock)
  );

  // Lock model and write/bypass monitor
  always_comb for (int i = 0; i < NP; i++) lock[i] = (lock_cnt[i] >= lock_dly[i]);

  logic [NP-1:0] prev_byp;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_byp <= bypass;
    for (int i = 0; i < NP; i++)
      if (rst_n && (prev_byp[i] && !bypass[i])) fall_cyc <= cyc;
    if (rst_n && wr_en) begin
      if (int'(wr_sel) != (wr_total % 4)) seq_err <= seq_err + 1;
      wdata[wr_sel] <= wr_data;
      wpll[wr_sel]  <= wr_pll;
      wr_total <= wr_total + 1;
      if (wr_sel == 2'd3) m_wr_cyc <= cyc;
    end
    for (int i = 0; i < NP; i++)
      if (rst_n && wr_en && wr_pll == 2'(i)) lock_cnt[i] <= 0;
      else if (lock_cnt[i] < NEVER) lock_cnt[i] <= lock_cnt[i] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cfg_good(input int p, input int n);
    return (CLKIN * n >= 800 * p) && (CLKIN * n <= 1600 * p) &&
           (CLKIN >= 10 * p) && (CLKIN <= 60 * p);
  endfunction

  function automatic int h_of(input int m, input int f);
    return ((m * f) % 8 == 0) ? 10 : 0;
  endfunction

  task automatic run(input int idx, input int p, input int n, input int f,
                     input int m, input int dly, input bit poke);
    int start = wr_total;
    bit good = cfg_good(p, n);
    int settle = (idx == 3) ? S_AUD : S_OTH;
    logic [NP-1:0] byp_before;
    lock_dly[idx] = dly;
    @(negedge clk);
    req_valid = 1'b1; req_pll = 2'(idx); req_p = 8'(p); req_n = 12'(n);
    req_f = 8'(f); req_m = 8'(m);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !done && !erng && !elock, "R10 flags cleared on accept",
        {done, erng, elock}, 0);
    byp_before = bypass;
    if (good) begin
      while (wr_total < start + 4) @(negedge clk);
      chk(bypass[idx] == 1'b1, "R5 bypass held during programming", bypass[idx], 1);
      if (poke) begin
        req_valid = 1'b1; req_pll = 2'(idx ^ 1); req_p = 8'd1; req_n = 12'd40;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!good) begin
      chk(erng && !done && !elock, "R2 reject flag", erng, 1);
      chk(wr_total == start, "R2 no writes on reject", wr_total - start, 0);
      chk(bypass == byp_before, "R2 bypass unchanged", bypass, byp_before);
    end else begin
      chk(wr_total == start + 4, "R3/R9 write count", wr_total - start, 4);
      chk(seq_err == 0, "R3 field order", seq_err, 0);
      chk(wpll[0] == 2'(idx) && wpll[3] == 2'(idx) && wpll[1] == 2'(idx) &&
          wpll[2] == 2'(idx), "R3 target index", wpll[3], idx);
      chk(wdata[0] == 16'(p) && wdata[1] == 16'(n) && wdata[2] == 16'(f),
          "R3 field data", wdata[1], n);
      chk(wdata[3] == 16'((h_of(m, f) << 8) | m), "R4 M with H",
          wdata[3], (h_of(m, f) << 8) | m);
      if (dly < NEVER) begin
        exp_byp[idx] = 1'b0;
        chk(done && !erng && !elock, "R7 done after lock", done, 1);
        chk(fall_cyc - m_wr_cyc > settle, "R6 settle before release",
            fall_cyc - m_wr_cyc, settle + 1);
      end else begin
        exp_byp[idx] = 1'b1;
        chk(elock && !done, "R8 lock timeout flag", elock, 1);
      end
      chk(bypass == exp_byp, "R7/R8/R9 bypass vector", bypass, exp_byp);
    end
    repeat (3) @(negedge clk);
    chk(done == (good && dly < NEVER) && erng == !good, "R10 flags persist",
        {done, erng}, {good && dly < NEVER, !good});
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin lock_cnt[i] = 0; lock_dly[i] = NEVER; end
    prev_byp = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_pll = '0; req_p = '0; req_n = '0;
    req_f = '0; req_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_byp = 4'b1101;
    chk(bypass == 4'b1101, "R1 reset bypass", bypass, 4'b1101);
    chk(!busy && !wr_en && !done && !erng && !elock, "R1 reset outputs",
        {busy, wr_en, done, erng, elock}, 0);
    // Directed corners
    run(0, 1, 30, 2, 4, 10, 0);        // edge low VCO 810, H=10
    run(3, 1, 59, 3, 3, S_AUD + 100, 0); // audio, late lock, H=0
    run(2, 1, 29, 1, 1, 5, 0);         // VCO 783 below window
    run(2, 1, 60, 1, 1, 5, 0);         // VCO 1620 above window
    run(2, 3, 100, 1, 1, 5, 0);        // ref 9 MHz below window
    run(2, 0, 40, 1, 1, 5, 0);         // P = 0
    run(2, 2, 70, 16, 5, NEVER, 0);    // never locks
    run(1, 1, 40, 7, 9, 20, 1);        // reprogram running PLL, poke while busy
    run(0, 2, 100, 8, 3, 0, 1);        // already locked, poke
    // Constrained random
    begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      for (int k = 0; k < 30; k++) begin
        int sel = $urandom_range(0, 9);
        int d = (sel < 6) ? $urandom_range(0, 60) :
                (sel < 8) ? S_AUD + $urandom_range(0, 100) : NEVER;
        int idx = $urandom_range(0, 3);
        if (d > S_OTH && d < NEVER && idx != 3) d = S_OTH + $urandom_range(0, 100);
        run(idx, $urandom_range(0, 3), $urandom_range(20, 130),
            $urandom_range(0, 255), $urandom_range(0, 255), d, k[0]);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule